// File: doc/BRIEF.md
# Serial Flash Boot Image Reader

This block fetches a boot image from an external serial flash as soon as reset is released. It is always the bus master: it drives the active-low select, the serial clock and the outgoing data line, and it samples the incoming data line. It first waits with the select inactive. It then picks a read command from a small selector input and shifts out that command and an all-zero 24-bit start address. After that it keeps clocking and hands the returned bytes downstream over a valid/ready byte port.

The serial clock is the system clock divided by a parameter. The bus runs in mode 0: the clock idles low, outgoing bits change on falling edges and incoming bits are sampled on rising edges. The transfer ends when a programmable number of bytes has been accepted or when an external stop input is raised. When a byte is waiting and the consumer is not ready, the serial clock is held low so that no further bit arrives. A selector value with no command behind it never starts a transfer and raises an error flag instead.

Top module: `flash_image_loader`

## Requirements
- R1: During reset and after it, `csN` is 1, `sck` is 0, `dataValid` is 0 and `selError` is 0. After reset, `csN` stays high for at least one full serial clock period (2*SCK_HALF system cycles) before it first goes low.
- R2: The serial clock idles low whenever `csN` is high. While a transfer runs, each high phase of `sck` lasts SCK_HALF system cycles. `mosi` changes only on a falling `sck` edge.
- R3: With `variantSel` = 2'b00, the block sends opcode 8'h03 and then 24 zero address bits, all MSB first. The first data bit is the one sampled on the rising edge right after the last address bit.
- R4: With `variantSel` = 2'b01, the block sends opcode 8'h0B, 24 zero address bits and then 8 extra clocks whose incoming bits are discarded. Data begins after those 40 header clocks.
- R5: With `variantSel` = 2'b10 or 2'b11, `selError` rises, `csN` stays high and `sck` never toggles until the next reset. `variantSel` is read once, at the end of the post-reset wait.
- R6: The level of `miso` during the header clocks has no effect on any delivered byte.
- R7: Received bits are packed MSB first. The first data bit sampled becomes bit 7 of the first byte on `dataOut`.
- R8: Once a byte is presented, `dataValid` stays high and `dataOut` stays stable until `dataReady` is high. While a byte waits, `sck` does not rise.
- R9: With `byteLimit` nonzero, on the clock edge where the byteLimit-th byte is accepted (dataValid and dataReady both high), `csN` goes high and `sck` goes low. No further byte is then presented.
- R10: `byteLimit` = 0 means no byte limit. The stream keeps running until `doneIn`.
- R11: On the first clock edge with `doneIn` high during a transfer, `csN` goes high, `sck` goes low and `dataValid` goes low. A partly received byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| variantSel | input | 2 | Read-command selector (00 normal read, 01 read with one dummy byte) |
| byteLimit | input | COUNT_W | Number of bytes to fetch, 0 for no limit |
| doneIn | input | 1 | Stops the transfer |
| sck | output | 1 | Serial clock to flash |
| csN | output | 1 | Active-low flash select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| dataOut | output | 8 | Assembled byte |
| dataValid | output | 1 | dataOut holds a byte |
| dataReady | input | 1 | Consumer accepts the byte |
| selError | output | 1 | Selector value has no command |

## Verification
A wrong bit or rise counter in this block shows up first as a wrong opcode or a nonzero address bit seen by the flash model, within the first 40 serial clocks. Shortly after that, every byte the scoreboard compares is shifted by a bit position. A fault in the stall or handshake logic shows up at the byte port within one serial clock: the clock keeps rising, `dataValid` drops or `dataOut` changes while the consumer holds ready low. A faulty terminator leaves `csN` low, or lets an extra byte appear, on the clock edge right after the last accepted byte or after `doneIn`.

// File: rtl/flash_loader_pkg.sv
package flash_loader_pkg;

  localparam int SEL_W    = 2;
  localparam int HDR_SHORT = 32;
  localparam int HDR_LONG  = 40;

  typedef struct packed {
    logic loadHdr;
    logic shiftHdr;
    logic sampleBit;
    logic captureByte;
  } dpStrobe_t;

  typedef enum logic [1:0] {ST_WAIT, ST_SHIFT, ST_HALT, ST_FAULT} loadState_t;

  function automatic logic selKnown(input logic [SEL_W-1:0] sel);
    return (sel == 2'b00) || (sel == 2'b01);
  endfunction

  function automatic logic selDummy(input logic [SEL_W-1:0] sel);
    return sel == 2'b01;
  endfunction

  function automatic logic [7:0] selOpcode(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b00:   return 8'h03;
      2'b01:   return 8'h0B;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_loader_dp.sv
module flash_loader_dp
  import flash_loader_pkg::*;
#(
  parameter int HDR_W = HDR_LONG
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [7:0] opcode,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] dataOut
);

  logic [HDR_W-1:0] hdrReg;
  logic [7:0]       rxReg;
  logic [7:0]       outReg;

  // command/address shifter: opcode on top, zero address and dummy below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg <= '0;
    end else if (stb.loadHdr) begin
      hdrReg <= {opcode, {(HDR_W-8){1'b0}}};
    end else if (stb.shiftHdr) begin
      hdrReg <= {hdrReg[HDR_W-2:0], 1'b0};
    end
  end

  // incoming byte assembler, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg  <= '0;
      outReg <= '0;
    end else begin
      if (stb.sampleBit)   rxReg  <= {rxReg[6:0], miso};
      if (stb.captureByte) outReg <= {rxReg[6:0], miso};
    end
  end

  assign mosi    = hdrReg[HDR_W-1];
  assign dataOut = outReg;

endmodule

// File: rtl/flash_loader_ctrl.sv
module flash_loader_ctrl
  import flash_loader_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int COUNT_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   variantSel,
  input  logic [COUNT_W-1:0] byteLimit,
  input  logic               doneIn,
  input  logic               dataReady,
  output logic               sck,
  output logic               csN,
  output logic               dataValid,
  output logic               selError,
  output dpStrobe_t          stb
);

  localparam int DIV_W     = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int WAIT_LAST = 2 * SCK_HALF;
  localparam int WAIT_W    = $clog2(WAIT_LAST + 1);
  localparam int RISE_W    = $clog2(HDR_LONG + 1);

  loadState_t         state;
  logic [DIV_W-1:0]   divCnt;
  logic [WAIT_W-1:0]  waitCnt;
  logic [RISE_W-1:0]  riseCnt;
  logic [RISE_W-1:0]  hdrLen;
  logic [2:0]         bitInByte;
  logic [COUNT_W-1:0] acceptCnt;
  logic sckQ, csNQ, validQ, errQ;

  logic tick, inData, handshake, stall, lastAccept, stopNow, active, waitDone;

  assign tick       = divCnt == DIV_W'(SCK_HALF - 1);
  assign inData     = riseCnt == hdrLen;
  assign handshake  = validQ && dataReady;
  assign stall      = validQ && !dataReady;
  assign lastAccept = handshake && (byteLimit != '0) && (acceptCnt == byteLimit - COUNT_W'(1));
  assign stopNow    = doneIn || lastAccept;
  assign active     = (state == ST_SHIFT) && !stopNow;
  assign waitDone   = waitCnt == WAIT_W'(WAIT_LAST);

  always_comb begin
    stb.loadHdr     = (state == ST_WAIT) && !doneIn && waitDone && selKnown(variantSel);
    stb.shiftHdr    = active && tick && sckQ;
    stb.sampleBit   = active && tick && !sckQ && !stall && inData;
    stb.captureByte = stb.sampleBit && (bitInByte == 3'd7);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_WAIT;
      divCnt    <= '0;
      waitCnt   <= '0;
      riseCnt   <= '0;
      hdrLen    <= '0;
      bitInByte <= '0;
      acceptCnt <= '0;
      sckQ      <= 1'b0;
      csNQ      <= 1'b1;
      validQ    <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (doneIn) begin
            state <= ST_HALT;
          end else if (waitDone) begin
            if (selKnown(variantSel)) begin
              state  <= ST_SHIFT;
              csNQ   <= 1'b0;
              hdrLen <= selDummy(variantSel) ? RISE_W'(HDR_LONG) : RISE_W'(HDR_SHORT);
            end else begin
              state <= ST_FAULT;
              errQ  <= 1'b1;
            end
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (handshake) begin
            validQ    <= 1'b0;
            acceptCnt <= acceptCnt + 1'b1;
          end
          if (stopNow) begin
            state  <= ST_HALT;
            csNQ   <= 1'b1;
            sckQ   <= 1'b0;
            validQ <= 1'b0;
          end else if (tick) begin
            if (sckQ) begin
              sckQ   <= 1'b0;
              divCnt <= '0;
            end else if (!stall) begin
              sckQ   <= 1'b1;
              divCnt <= '0;
              if (!inData) begin
                riseCnt <= riseCnt + 1'b1;
              end else begin
                bitInByte <= bitInByte + 1'b1;
                if (bitInByte == 3'd7) validQ <= 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sck       = sckQ;
  assign csN       = csNQ;
  assign dataValid = validQ;
  assign selError  = errQ;

  p_idle_clock_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    csNQ |-> !sckQ);

  p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !dataReady && !doneIn) |=> validQ);

  p_no_rise_while_waiting_r8: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !dataReady) |=> !$rose(sckQ));

  p_fault_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (csNQ && !validQ && !sckQ));

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && state == ST_SHIFT) |=> (csNQ && !sckQ && !validQ));

endmodule

// File: rtl/flash_image_loader.sv
module flash_image_loader
  import flash_loader_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int COUNT_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         variantSel,
  input  logic [COUNT_W-1:0] byteLimit,
  input  logic               doneIn,
  output logic               sck,
  output logic               csN,
  output logic               mosi,
  input  logic               miso,
  output logic [7:0]         dataOut,
  output logic               dataValid,
  input  logic               dataReady,
  output logic               selError
);

  dpStrobe_t  stb;
  logic [7:0] opcodeSel;

  assign opcodeSel = selOpcode(variantSel);

  flash_loader_ctrl #(.SCK_HALF(SCK_HALF), .COUNT_W(COUNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .variantSel (variantSel),
    .byteLimit  (byteLimit),
    .doneIn     (doneIn),
    .dataReady  (dataReady),
    .sck        (sck),
    .csN        (csN),
    .dataValid  (dataValid),
    .selError   (selError),
    .stb        (stb)
  );

  flash_loader_dp #(.HDR_W(HDR_LONG)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .opcode  (opcodeSel),
    .miso    (miso),
    .mosi    (mosi),
    .dataOut (dataOut)
  );

  // outgoing bit moves only together with a falling serial clock
  p_mosi_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && (mosi != $past(mosi))) |-> (!sck && $past(sck)));

endmodule

// File: tb/tb_flash_image_loader.sv
module tb_flash_image_loader;

  localparam int HALF    = 2;
  localparam int COUNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] variantSel = 2'b00;
  logic [COUNT_W-1:0] byteLimit = '0;
  logic doneIn = 1'b0;
  logic miso = 1'b1;
  logic dataReady = 1'b1;
  logic sck, csN, mosi, dataValid, selError;
  logic [7:0] dataOut;

  int checks = 0;
  int errors = 0;
  int recvCount = 0;
  int widthErr = 0;
  int hiCnt = 0;
  logic [7:0] expQ[$];

  always #5 clk = ~clk;

  flash_image_loader #(.SCK_HALF(HALF), .COUNT_W(COUNT_W)) dut (
    .clk(clk), .rstN(rstN), .variantSel(variantSel), .byteLimit(byteLimit),
    .doneIn(doneIn), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .dataOut(dataOut), .dataValid(dataValid), .dataReady(dataReady), .selError(selError)
  );

  function automatic logic [7:0] byteAt(input int k);
    return 8'(k * 53 + 17);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model: captures header bits on rising sck, launches data on falling sck
  logic [39:0] cmdSeen;
  int flashRise = 0;
  int hdrExp = 32;

  always @(negedge csN) begin
    flashRise = 0;
    miso = 1'b1;
  end

  always @(posedge sck) begin
    if (!csN) begin
      if (flashRise < 40) cmdSeen = {cmdSeen[38:0], mosi};
      flashRise++;
    end
  end

  always @(negedge sck) begin : flashOut
    int j;
    if (flashRise >= hdrExp) begin
      j = flashRise - hdrExp;
      #1 miso = byteAt(j / 8)[7 - (j % 8)];
    end
  end

  // monitor: scoreboard compare on each accepted byte
  always @(negedge clk) begin : monitor
    logic [7:0] e;
    if (rstN && dataValid && dataReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected byte", dataOut, 0);
      end else begin
        e = expQ.pop_front();
        check(dataOut === e, "R7 byte value", dataOut, e);
      end
      recvCount++;
    end
  end

  // serial clock high-phase width
  always @(negedge clk) begin
    if (sck) hiCnt++;
    else begin
      if (hiCnt != 0 && !csN && hiCnt != HALF) widthErr++;
      hiCnt = 0;
    end
  end

  task automatic doReset(input logic [1:0] sel, input int limit, input bit expectStart);
    int highCnt;
    variantSel = sel;
    byteLimit  = COUNT_W'(limit);
    doneIn     = 1'b0;
    hdrExp     = (sel == 2'b01) ? 40 : 32;
    expQ.delete();
    recvCount = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(csN === 1'b1 && sck === 1'b0 && dataValid === 1'b0 && selError === 1'b0,
          "R1 reset state", {csN, sck, dataValid, selError}, 4'b1000);
    rstN = 1'b1;
    if (expectStart) begin
      highCnt = 0;
      @(negedge clk);
      while (csN && highCnt < 100) begin
        highCnt++;
        @(negedge clk);
      end
      check(highCnt >= 2 * HALF && highCnt < 100, "R1 select hold after reset", highCnt, 2 * HALF);
    end
  endtask

  task automatic waitEnd(input string req);
    int n = 0;
    while (!csN && n < 50000) begin
      @(negedge clk);
      n++;
    end
    check(csN === 1'b1 && sck === 1'b0, req, {csN, sck}, 2'b10);
  endtask

  initial begin
    logic [7:0] held;
    bit ok;

    // normal read, five bytes
    doReset(2'b00, 5, 1'b1);
    for (int k = 0; k < 5; k++) expQ.push_back(byteAt(k));
    waitEnd("R9 stop after limit");
    repeat (40) @(negedge clk);
    check(recvCount == 5 && expQ.size() == 0, "R9 byte count", recvCount, 5);
    check(cmdSeen[39:32] == 8'h03, "R3 opcode", cmdSeen[39:32], 8'h03);
    check(cmdSeen[31:8] == 24'h0, "R3 address", cmdSeen[31:8], 0);
    check(csN === 1'b1 && sck === 1'b0, "R2 idle after end", {csN, sck}, 2'b10);

    // dummy-byte read, consumer stalls on the first byte
    dataReady = 1'b0;
    doReset(2'b01, 4, 1'b1);
    for (int k = 0; k < 4; k++) expQ.push_back(byteAt(k));
    while (!dataValid) @(negedge clk);
    held = dataOut;
    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!dataValid || dataOut !== held) ok = 1'b0;
    end
    check(ok, "R8 byte held while not ready", dataOut, held);
    check(sck === 1'b0, "R8 clock parked low", sck, 0);
    check(recvCount == 0, "R8 nothing accepted", recvCount, 0);
    dataReady = 1'b1;
    waitEnd("R9 stop after limit with stall");
    repeat (20) @(negedge clk);
    check(recvCount == 4 && expQ.size() == 0, "R6 R4 bytes after dummy", recvCount, 4);
    check(cmdSeen[39:32] == 8'h0B, "R4 opcode", cmdSeen[39:32], 8'h0B);
    check(cmdSeen[31:8] == 24'h0, "R4 address", cmdSeen[31:8], 0);

    // limit of one byte
    doReset(2'b00, 1, 1'b1);
    expQ.push_back(byteAt(0));
    waitEnd("R9 stop after single byte");
    repeat (40) @(negedge clk);
    check(recvCount == 1, "R9 single byte", recvCount, 1);

    // no limit, stopped by doneIn
    doReset(2'b00, 0, 1'b1);
    for (int k = 0; k < 6; k++) expQ.push_back(byteAt(k));
    wait (recvCount == 6);
    check(!csN, "R10 still streaming past six bytes", csN, 0);
    doneIn = 1'b1;
    @(negedge clk);
    check(csN === 1'b1 && sck === 1'b0 && dataValid === 1'b0, "R11 stop on doneIn",
          {csN, sck, dataValid}, 3'b100);
    doneIn = 1'b0;
    repeat (60) @(negedge clk);
    check(recvCount == 6 && csN === 1'b1, "R11 no bytes after stop", recvCount, 6);

    // undefined selectors
    for (int s = 2; s < 4; s++) begin
      doReset(2'(s), 3, 1'b0);
      ok = 1'b1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (!csN || sck) ok = 1'b0;
      end
      check(ok && selError === 1'b1, "R5 unknown selector", {csN, sck, selError}, 3'b101);
      check(recvCount == 0, "R5 no bytes", recvCount, 0);
    end

    check(widthErr == 0, "R2 clock high width", widthErr, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule